// File: doc/BRIEF.md
# Sequential Lookup-Table Scanner

This block finds one entry in a forwarding table by walking it from index 0 upward, reading one 64-bit entry per clock through a synchronous read port. A single start pulse selects one of four qualification rules, and the scan stops at the first entry that meets the rule. The rules are:

- an address entry whose MAC address and VLAN ID both equal the key;
- a VLAN entry with a given ID;
- the first unused slot;
- the first unicast address entry that ageing may reclaim.

When the scan passes the last configured index without a hit, the block reports not-found. Upper control logic uses the returned index to pick a slot to overwrite or to update. Writing entries is handled elsewhere.

The entry layout the block decodes is as follows:

| Bits | Field |
|------|-------|
| 63:62 | unicast class (0 persistent, 1 untouched, 2 OUI-based, 3 touched) |
| 61:60 | entry kind (0 free, 1 address, 2 VLAN, 3 VLAN+address) |
| 59:48 | VLAN ID |
| 47:0 | MAC address (bit 40 is the multicast flag) |

Top module: `table_scan_engine`

## Requirements
- R1: With mode 0, an entry qualifies only when its kind field (bits 61:60) is 1 or 3, its VLAN ID (bits 59:48) equals the VLAN key, and bits 47:0 equal the 48-bit MAC key.
- R2: With mode 1, an entry qualifies only when its kind field is 2 and its VLAN ID equals the VLAN key.
- R3: With mode 2, an entry qualifies when its kind field is 0.
- R4: With mode 3, an entry qualifies only when its kind field is 1 or 3 and bit 40 (multicast) is clear.
- R5: With mode 3, the unicast class in bits 63:62 must additionally be 1 or 3; classes 0 and 2 never qualify.
- R6: Reads are issued at addresses 0, 1, 2, … on consecutive cycles, and the reported index is the lowest qualifying index.
- R7: When no entry from 0 through `last_idx` qualifies, the block asserts done with found low and index 0, and it never reads an address above `last_idx`.
- R8: A start while a scan is running is ignored. Mode, keys and `last_idx` are sampled only on the cycle a start is accepted.
- R9: Done is high for exactly one cycle. For a hit at index k, done is first visible k+2 rising edges after the edge that accepts start. For a miss, it is visible `last_idx`+2 edges after that edge. Found and index then hold until the next accepted start.
- R10: After reset, done, found and rd_en are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| start | input | 1 | begin a scan (accepted when idle) |
| mode | input | 2 | rule: 0 address, 1 VLAN, 2 free, 3 ageable |
| key_mac | input | 48 | MAC key |
| key_vid | input | 12 | VLAN ID key |
| last_idx | input | IDX_W | highest index to examine |
| rd_en | output | 1 | table read request |
| rd_addr | output | IDX_W | table read address |
| rd_data | input | 64 | entry returned one cycle after the request |
| done | output | 1 | one-cycle completion pulse |
| found | output | 1 | a qualifying entry was found |
| index | output | IDX_W | index of that entry |

## Verification
The bench plants decoys ahead of the true hit. These include a VLAN entry carrying the key address, an address entry one VLAN off, an address entry one MAC bit off, and persistent, OUI-based and multicast address entries ahead of an ageable one. A design that decoded the wrong field would stop early on one of these.

It also places hits at index 0 and exactly at `last_idx`, and a hit one beyond `last_idx`. An off-by-one in the stop test would miss the boundary hit or report the one past it.

A second start with different keys arrives in mid-scan. A design that re-armed would return a free slot or restart.

Completion is timed against the cycle count, so a compare stage misaligned with the read latency would report a neighbouring index or finish a cycle off.

// File: rtl/tse_pkg.sv
package tse_pkg;

  localparam int ENTRY_W = 64;
  localparam int MAC_W   = 48;
  localparam int VID_W   = 12;

  typedef enum logic [1:0] {
    MODE_ADDR = 2'd0,
    MODE_VLAN = 2'd1,
    MODE_FREE = 2'd2,
    MODE_AGE  = 2'd3
  } scan_mode_e;

  function automatic logic [1:0] ent_kind(input logic [ENTRY_W-1:0] e);
    return e[61:60];
  endfunction

  function automatic logic [VID_W-1:0] ent_vid(input logic [ENTRY_W-1:0] e);
    return e[59:48];
  endfunction

  function automatic logic [1:0] ent_class(input logic [ENTRY_W-1:0] e);
    return e[63:62];
  endfunction

  function automatic logic carries_addr(input logic [ENTRY_W-1:0] e);
    return (ent_kind(e) == 2'd1) || (ent_kind(e) == 2'd3);
  endfunction

  function automatic logic entry_qualifies(input scan_mode_e m,
                                           input logic [ENTRY_W-1:0] e,
                                           input logic [MAC_W-1:0] mac,
                                           input logic [VID_W-1:0] vid);
    logic q;
    unique case (m)
      MODE_ADDR: q = carries_addr(e) && (ent_vid(e) == vid) && (e[MAC_W-1:0] == mac);
      MODE_VLAN: q = (ent_kind(e) == 2'd2) && (ent_vid(e) == vid);
      MODE_FREE: q = (ent_kind(e) == 2'd0);
      MODE_AGE:  q = carries_addr(e) && !e[40] &&
                     ((ent_class(e) == 2'd1) || (ent_class(e) == 2'd3));
      default:   q = 1'b0;
    endcase
    return q;
  endfunction

endpackage

// File: rtl/tse_cursor.sv
module tse_cursor #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             halt,
  input  logic [IDX_W-1:0] last_idx,
  output logic             rd_en,
  output logic [IDX_W-1:0] rd_addr,
  output logic             cmp_valid,
  output logic [IDX_W-1:0] cmp_idx,
  output logic             cmp_last
);

  logic             issue_q;
  logic [IDX_W-1:0] addr_q;
  logic             pv_q;
  logic [IDX_W-1:0] pidx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issue_q <= 1'b0;
      addr_q  <= '0;
      pv_q    <= 1'b0;
      pidx_q  <= '0;
    end else if (launch) begin
      issue_q <= 1'b1;
      addr_q  <= '0;
      pv_q    <= 1'b0;
    end else if (halt) begin
      issue_q <= 1'b0;
      pv_q    <= 1'b0;
    end else begin
      pv_q   <= issue_q;
      pidx_q <= addr_q;
      if (issue_q) begin
        if (addr_q == last_idx) issue_q <= 1'b0;
        else                    addr_q  <= addr_q + 1'b1;
      end
    end
  end

  assign rd_en     = issue_q;
  assign rd_addr   = addr_q;
  assign cmp_valid = pv_q;
  assign cmp_idx   = pidx_q;
  assign cmp_last  = (pidx_q == last_idx);

  // R6: compared entries arrive in ascending consecutive order
  a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && $past(cmp_valid) |-> (cmp_idx - $past(cmp_idx)) == IDX_W'(1));

  // R7: no read beyond the configured last index
  a_r7_no_overread: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !$past(launch) |-> rd_addr <= last_idx);

endmodule

// File: rtl/tse_qualify.sv
module tse_qualify
  import tse_pkg::*;
(
  input  scan_mode_e         mode,
  input  logic [ENTRY_W-1:0] entry,
  input  logic [MAC_W-1:0]   mac,
  input  logic [VID_W-1:0]   vid,
  output logic               hit
);

  always_comb hit = entry_qualifies(mode, entry, mac, vid);

endmodule

// File: rtl/table_scan_engine.sv
module table_scan_engine
  import tse_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         mode,
  input  logic [MAC_W-1:0]   key_mac,
  input  logic [VID_W-1:0]   key_vid,
  input  logic [IDX_W-1:0]   last_idx,
  output logic               rd_en,
  output logic [IDX_W-1:0]   rd_addr,
  input  logic [ENTRY_W-1:0] rd_data,
  output logic               done,
  output logic               found,
  output logic [IDX_W-1:0]   index
);

  logic             busy_q;
  scan_mode_e       mode_q;
  logic [MAC_W-1:0] mac_q;
  logic [VID_W-1:0] vid_q;
  logic [IDX_W-1:0] last_q;
  logic             done_q;
  logic             found_q;
  logic [IDX_W-1:0] index_q;

  logic             cmp_valid;
  logic [IDX_W-1:0] cmp_idx;
  logic             cmp_last;
  logic             hit_w;
  logic             launch_w;
  logic             finish_w;

  assign launch_w = start && !busy_q;
  assign finish_w = busy_q && cmp_valid && (hit_w || cmp_last);

  tse_cursor #(.IDX_W(IDX_W)) u_cursor (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch_w),
    .halt      (finish_w),
    .last_idx  (last_q),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .cmp_valid (cmp_valid),
    .cmp_idx   (cmp_idx),
    .cmp_last  (cmp_last)
  );

  tse_qualify u_qualify (
    .mode  (mode_q),
    .entry (rd_data),
    .mac   (mac_q),
    .vid   (vid_q),
    .hit   (hit_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      mode_q  <= MODE_ADDR;
      mac_q   <= '0;
      vid_q   <= '0;
      last_q  <= '0;
      done_q  <= 1'b0;
      found_q <= 1'b0;
      index_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (launch_w) begin
        busy_q  <= 1'b1;
        mode_q  <= scan_mode_e'(mode);
        mac_q   <= key_mac;
        vid_q   <= key_vid;
        last_q  <= last_idx;
        found_q <= 1'b0;
        index_q <= '0;
      end else if (finish_w) begin
        busy_q  <= 1'b0;
        done_q  <= 1'b1;
        found_q <= hit_w;
        index_q <= hit_w ? cmp_idx : '0;
      end
    end
  end

  assign done  = done_q;
  assign found = found_q;
  assign index = index_q;

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R9: found only rises together with done
  a_r9_found_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(found_q) |-> done_q);

  // R8: a start during a scan leaves the sampled keys untouched
  a_r8_keys_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && start |=> $stable(mac_q) && $stable(vid_q) && $stable(mode_q) && $stable(last_q));

  // R7: a reported hit lies inside the configured range
  a_r7_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && found_q |-> index_q <= last_q);

endmodule

// File: tb/table_scan_engine_tb.sv
`timescale 1ns/1ps
module table_scan_engine_tb;

  localparam int DEPTH = 64;
  localparam int IDX_W = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [47:0] key_mac = '0;
  logic [11:0] key_vid = '0;
  logic [IDX_W-1:0] last_idx = '0;
  logic        rd_en;
  logic [IDX_W-1:0] rd_addr;
  logic [63:0] rd_data;
  logic        done, found;
  logic [IDX_W-1:0] index;

  logic [63:0] mem [DEPTH];

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  table_scan_engine #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .key_mac(key_mac), .key_vid(key_vid), .last_idx(last_idx),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .done(done), .found(found), .index(index)
  );

  function automatic logic [63:0] mk(input logic [1:0] cls, input logic [1:0] kind,
                                     input logic [11:0] vid, input logic [47:0] mac);
    return {cls, kind, vid, mac};
  endfunction

  // independent model of the qualification rules
  function automatic bit ref_ok(input logic [1:0] m, input logic [63:0] e,
                                input logic [47:0] mac, input logic [11:0] vid);
    bit is_addr;
    is_addr = (e[61:60] inside {2'd1, 2'd3});
    case (m)
      2'd0: return is_addr && e[59:48] == vid && e[47:0] == mac;
      2'd1: return e[61:60] == 2'd2 && e[59:48] == vid;
      2'd2: return e[61:60] == 2'd0;
      default: return is_addr && (e[40] == 1'b0) && (e[63:62] inside {2'd1, 2'd3});
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic fill_base();
    for (int i = 0; i < DEPTH; i++) mem[i] = mk(2'd1, 2'd2, 12'hFFF, 48'h0A00_0000_0000 | 48'(i));
  endtask

  task automatic run_search(input logic [1:0] m, input logic [47:0] mac, input logic [11:0] vid,
                            input int last, input bit poke, input string req);
    bit exp_f = 0;
    int exp_i = 0;
    int n, exp_n, exp_a;
    bit order_ok = 1, got = 0;
    logic [IDX_W-1:0] held_i;
    for (int i = 0; i <= last; i++)
      if (!exp_f && ref_ok(m, mem[i], mac, vid)) begin exp_f = 1; exp_i = i; end
    exp_n = (exp_f ? exp_i : last) + 3;
    @(negedge clk);
    start = 1; mode = m; key_mac = mac; key_vid = vid; last_idx = IDX_W'(last);
    @(negedge clk);
    start = 0; n = 1; exp_a = 0;
    while (n < 2000) begin
      if (rd_en) begin
        if (rd_addr != IDX_W'(exp_a)) order_ok = 0;
        exp_a++;
      end
      if (done) begin got = 1; break; end
      if (poke && n == 2) begin start = 1; mode = 2'd2; key_mac = ~mac; key_vid = ~vid; last_idx = '0; end
      if (poke && n == 3) start = 0;
      @(negedge clk); n++;
    end
    chk(got, req, "done reached (watchdog)", got, 1);
    chk(found == exp_f, req, "found", found, exp_f);
    chk(index == IDX_W'(exp_i), req, "index", index, exp_i);
    chk(n == exp_n, "R9", "cycles to done", n, exp_n);
    chk(order_ok, "R6", "read order ascending", order_ok, 1);
    chk(exp_a <= last + 1, "R7", "reads within last_idx", exp_a, last + 1);
    held_i = index;
    @(negedge clk);
    chk(!done, "R9", "done single cycle", done, 0);
    chk(found == exp_f && index == held_i, "R9", "result held", index, held_i);
  endtask

  task automatic t_reset();
    chk(!done && !found && !rd_en, "R10", "outputs low after reset", {done, found, rd_en}, 0);
  endtask

  task automatic t_addr();
    logic [47:0] a = 48'h0200_1234_5678;
    fill_base();
    mem[3]  = mk(2'd1, 2'd1, 12'h011, a);
    mem[4]  = mk(2'd1, 2'd2, 12'h010, a);
    mem[5]  = mk(2'd0, 2'd0, 12'h010, a);
    mem[7]  = mk(2'd1, 2'd1, 12'h010, a ^ 48'h1);
    mem[12] = mk(2'd0, 2'd1, 12'h010, a);
    mem[30] = mk(2'd0, 2'd1, 12'h010, a);
    run_search(2'd0, a, 12'h010, 63, 0, "R1");
    mem[12] = mk(2'd3, 2'd3, 12'h010, a);
    run_search(2'd0, a, 12'h010, 63, 0, "R1");
    mem[12] = mk(2'd0, 2'd0, 12'h010, a);
    run_search(2'd0, a, 12'h010, 63, 0, "R6");
  endtask

  task automatic t_vlan();
    fill_base();
    mem[2] = mk(2'd1, 2'd3, 12'h123, 48'h0);
    mem[6] = mk(2'd1, 2'd1, 12'h123, 48'h5);
    mem[9] = mk(2'd0, 2'd2, 12'h123, 48'h0);
    run_search(2'd1, 48'h0, 12'h123, 63, 0, "R2");
  endtask

  task automatic t_free();
    fill_base();
    mem[40] = mk(2'd3, 2'd0, 12'h000, 48'h0);
    run_search(2'd2, 48'h0, 12'h0, 63, 0, "R3");
    mem[0] = 64'h0;
    run_search(2'd2, 48'h0, 12'h0, 63, 0, "R3");
  endtask

  task automatic t_age();
    fill_base();
    mem[1] = mk(2'd0, 2'd1, 12'h1, 48'h0000_0000_0001);
    mem[2] = mk(2'd2, 2'd1, 12'h1, 48'h0000_0000_0002);
    mem[3] = mk(2'd1, 2'd1, 12'h1, 48'h0100_0000_0003);
    mem[4] = mk(2'd1, 2'd2, 12'h1, 48'h0000_0000_0004);
    mem[5] = mk(2'd3, 2'd3, 12'h1, 48'h0000_0000_0005);
    mem[6] = mk(2'd1, 2'd1, 12'h1, 48'h0000_0000_0006);
    run_search(2'd3, 48'h0, 12'h0, 63, 0, "R5");
    mem[5] = mk(2'd3, 2'd2, 12'h1, 48'h0000_0000_0005);
    run_search(2'd3, 48'h0, 12'h0, 63, 0, "R4");
  endtask

  task automatic t_miss();
    fill_base();
    run_search(2'd1, 48'h0, 12'h055, 63, 0, "R7");
    mem[50] = mk(2'd0, 2'd2, 12'h055, 48'h0);
    run_search(2'd1, 48'h0, 12'h055, 49, 0, "R7");
    run_search(2'd1, 48'h0, 12'h055, 50, 0, "R7");
  endtask

  task automatic t_busy();
    fill_base();
    mem[20] = mk(2'd0, 2'd1, 12'h077, 48'hAAAA_0000_BBBB);
    run_search(2'd0, 48'hAAAA_0000_BBBB, 12'h077, 63, 1, "R8");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    fill_base();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_addr();
    t_vlan();
    t_free();
    t_age();
    t_miss();
    t_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule